// File: doc/BRIEF.md
# Two-Channel LVDS Pixel Mode Router

This block sits between one or two parallel display pixel streams and a pair of LVDS transmit channels. Each channel turns one pixel per pixel period into seven serial bit slots on each of its data lanes, plus a forwarded clock lane. The whole block runs on the fast serial clock, and a shared seven-slot counter marks the pixel-clock boundary at which every lane loads a new seven-bit word.

A two-bit routing mode selects the way the inputs reach the channels. Single mode drives channel 0 only. Separate mode pairs each input with its own channel. Dual mode copies input A to both channels. Split mode takes input A at twice the per-channel rate and sends even pixels to channel 0 and odd pixels to channel 1. The mode and the lane-count option are sampled only at the start of a frame, so a running line is never torn.

Top module: `lvds_mode_router`

## Requirements
- R1: A shared counter raises a load event every 7 clock cycles, the first one on the 7th rising edge after reset is released. At each load, every lane takes a 7-bit word and emits it bit 6 first, one bit per clock cycle.
- R2: An enabled channel's clock lane repeats the word 1100011 (bit 6 first) from each load.
- R3: Mode 2'b00 (single): channel 0 carries the latest input-A pixel, and channel 1 holds all data lanes and its clock lane low.
- R4: Mode 2'b01 (separate): channel 0 carries the latest input-A pixel and channel 1 carries the latest input-B pixel.
- R5: Mode 2'b10 (dual): both channels carry the latest input-A pixel with identical serial output, and input B is ignored.
- R6: Mode 2'b11 (split): input-A pixels alternate even/odd. An even pixel is held until its odd partner arrives. The pair then goes to the channels, even on channel 0 and odd on channel 1, and the odd word takes its de, vs and hs bits from the even pixel.
- R7: An input-A pixel whose de is 1 while the previous input-A pixel had de 0 is always treated as even. A held even pixel that is still unpaired at that moment is discarded.
- R8: Lane word mapping, with bit 6 sent first: lane 0 = data[6:0]; lane 1 = data[13:7]; lane 2 = {de, vs, hs, data[17:14]}; lane 3 = {0, data[23:18]} when the wide option is 1, and all zeros when it is 0.
- R9: The mode and wide inputs are taken only on an input-A valid pixel whose vs is 1 while the previous input-A valid pixel had vs 0. At all other times, changes on them have no effect.
- R10: After reset all outputs are low, the mode is single and the wide option is 0.
- R11: A load uses the last valid pixel captured on an earlier edge. When no new pixel arrives in a pixel period, the same word is sent again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock, 7 cycles per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| mode_cfg | input | 2 | Requested routing mode, applied at frame start |
| wide_cfg | input | 1 | Requested lane option: 1 selects 4 lanes, 0 selects 3; applied at frame start |
| a_valid | input | 1 | Input A pixel strobe |
| a_de | input | 1 | Input A data enable |
| a_vs | input | 1 | Input A vertical sync |
| a_hs | input | 1 | Input A horizontal sync |
| a_data | input | 24 | Input A pixel data |
| b_valid | input | 1 | Input B pixel strobe |
| b_de | input | 1 | Input B data enable |
| b_vs | input | 1 | Input B vertical sync |
| b_hs | input | 1 | Input B horizontal sync |
| b_data | input | 24 | Input B pixel data |
| ch0_lane_o | output | 4 | Channel 0 serial data lanes |
| ch0_clk_o | output | 1 | Channel 0 forwarded clock lane |
| ch1_lane_o | output | 4 | Channel 1 serial data lanes |
| ch1_clk_o | output | 1 | Channel 1 forwarded clock lane |

## Verification
Two functions can meet on the same edge. The first pair is the line-start index reset and a still-pending even pixel in split mode. The bench provokes it by sending a blanking pixel that becomes the held even pixel, then a de-rising pixel in the same pixel period. The channels must keep repeating the previous pair, and the next pixel must pair with the de-rising one. The second pair is a frame-start mode switch and the split demultiplexer both acting on the same vsync pixel. Both cases are judged by rebuilding every serial word on both channels from a reference model of the requirements, and comparing the words bit by bit.

// File: rtl/lvdsr_pkg.sv
package lvdsr_pkg;

   localparam int PIX_BITS  = 24;
   localparam int SLOT_BITS = 7;
   localparam int LANES_MAX = 4;
   localparam int WORD_BITS = SLOT_BITS * LANES_MAX;

   typedef enum logic [1:0] {
      M_SINGLE   = 2'b00,
      M_SEPARATE = 2'b01,
      M_DUAL     = 2'b10,
      M_SPLIT    = 2'b11
   } route_mode_e;

   typedef struct packed {
      logic                de;
      logic                vs;
      logic                hs;
      logic [PIX_BITS-1:0] rgb;
   } pix_t;

   // R8: fixed slot order; control bits ride in lane 2, lane 3 only when wide
   function automatic logic [WORD_BITS-1:0] pack_lanes(input pix_t p, input logic wide);
      logic [WORD_BITS-1:0] w;
      w[6:0]   = p.rgb[6:0];
      w[13:7]  = p.rgb[13:7];
      w[20:14] = {p.de, p.vs, p.hs, p.rgb[17:14]};
      w[27:21] = wide ? {1'b0, p.rgb[23:18]} : 7'd0;
      return w;
   endfunction

endpackage

// File: rtl/lvdsr_slot_timer.sv
module lvdsr_slot_timer #(
   parameter int SLOTS = 7
) (
   input  logic clk,
   input  logic rst,
   output logic load_o
);
   localparam int CW = $clog2(SLOTS);
   localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign load_o = (cnt == LAST);

   if (SLOTS < 2) begin : g_bad_slots
      $error("lvdsr_slot_timer: SLOTS must be at least 2");
   end

   // R1: counter never leaves its range
   a_r1_slot_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);
   // R1: loads are never back to back
   a_r1_load_gap: assert property (@(posedge clk) disable iff (rst)
      load_o |=> !load_o);
endmodule

// File: rtl/lvdsr_cfg_gate.sv
module lvdsr_cfg_gate
   import lvdsr_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        a_valid,
   input  logic        a_vs,
   input  logic [1:0]  mode_cfg,
   input  logic        wide_cfg,
   output route_mode_e mode_q,
   output logic        wide_q
);
   logic vs_last;
   logic frame_start;

   assign frame_start = a_valid & a_vs & ~vs_last;

   always_ff @(posedge clk) begin
      if (rst) begin
         vs_last <= 1'b0;
         mode_q  <= M_SINGLE;
         wide_q  <= 1'b0;
      end else begin
         if (a_valid) vs_last <= a_vs;
         if (frame_start) begin
            mode_q <= route_mode_e'(mode_cfg);
            wide_q <= wide_cfg;
         end
      end
   end

   // R9: configuration holds unless a frame starts
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
      !frame_start |=> ($stable(mode_q) && $stable(wide_q)));
endmodule

// File: rtl/lvdsr_split_demux.sv
module lvdsr_split_demux
   import lvdsr_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic in_valid,
   input  pix_t in_pix,
   output pix_t even_o,
   output pix_t odd_o
);
   logic ph;        // 1: an even pixel is held
   logic de_last;
   pix_t hold;
   logic line_start;
   logic take_even;

   assign line_start = in_valid & in_pix.de & ~de_last;
   assign take_even  = line_start | ~ph;

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= 1'b0;
         de_last <= 1'b0;
         hold    <= '0;
         even_o  <= '0;
         odd_o   <= '0;
      end else if (in_valid) begin
         de_last <= in_pix.de;
         if (take_even) begin
            hold <= in_pix;
            ph   <= 1'b1;
         end else begin
            even_o <= hold;
            odd_o  <= '{de: hold.de, vs: hold.vs, hs: hold.hs, rgb: in_pix.rgb};
            ph     <= 1'b0;
         end
      end
   end

   // R7: a line start always leaves an even pixel held
   a_r7_line_start: assert property (@(posedge clk) disable iff (rst)
      line_start |=> ph);
   // R6: outside a line start the even/odd phase alternates
   a_r6_alternate: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !line_start) |=> (ph != $past(ph)));
endmodule

// File: rtl/lvdsr_chan_ser.sv
module lvdsr_chan_ser #(
   parameter int               LANES   = 4,
   parameter int               SLOTS   = 7,
   parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   load_i,
   input  logic                   en_i,
   input  logic [LANES*SLOTS-1:0] word_i,
   output logic [LANES-1:0]       lane_o,
   output logic                   clk_o
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SLOTS-1:0] sr;
      always_ff @(posedge clk) begin
         if (rst)         sr <= '0;
         else if (load_i) sr <= en_i ? word_i[g*SLOTS +: SLOTS] : '0;
         else             sr <= {sr[SLOTS-2:0], 1'b0};
      end
      assign lane_o[g] = sr[SLOTS-1];
   end

   logic [SLOTS-1:0] csr;
   always_ff @(posedge clk) begin
      if (rst)         csr <= '0;
      else if (load_i) csr <= en_i ? CLK_PAT : '0;
      else             csr <= {csr[SLOTS-2:0], 1'b0};
   end
   assign clk_o = csr[SLOTS-1];

   // R2: an enabled channel starts each pixel period with the clock pattern's lead bit
   a_r2_clk_lead: assert property (@(posedge clk) disable iff (rst)
      (load_i && en_i) |=> (clk_o == CLK_PAT[SLOTS-1]));
   // R3: a disabled channel is silent after the load
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      (load_i && !en_i) |=> (lane_o == '0 && !clk_o));
endmodule

// File: rtl/lvds_mode_router.sv
module lvds_mode_router
   import lvdsr_pkg::*;
#(
   parameter int               PIX_W   = 24,
   parameter int               SLOTS   = 7,
   parameter int               LANES   = 4,
   parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       mode_cfg,
   input  logic             wide_cfg,
   input  logic             a_valid,
   input  logic             a_de,
   input  logic             a_vs,
   input  logic             a_hs,
   input  logic [PIX_W-1:0] a_data,
   input  logic             b_valid,
   input  logic             b_de,
   input  logic             b_vs,
   input  logic             b_hs,
   input  logic [PIX_W-1:0] b_data,
   output logic [LANES-1:0] ch0_lane_o,
   output logic             ch0_clk_o,
   output logic [LANES-1:0] ch1_lane_o,
   output logic             ch1_clk_o
);
   localparam int NCH    = 2;
   localparam int WORD_W = LANES * SLOTS;

   if (PIX_W != PIX_BITS) begin : g_bad_pix
      $error("lvds_mode_router: PIX_W must match the lane mapping width");
   end
   if (WORD_W != WORD_BITS) begin : g_bad_word
      $error("lvds_mode_router: LANES*SLOTS must match the lane mapping");
   end

   logic        load;
   route_mode_e mode_q;
   logic        wide_q;
   pix_t        cap_a, cap_b, split_even, split_odd, in_a;

   assign in_a = '{de: a_de, vs: a_vs, hs: a_hs, rgb: a_data};

   always_ff @(posedge clk) begin
      if (rst) begin
         cap_a <= '0;
         cap_b <= '0;
      end else begin
         if (a_valid) cap_a <= in_a;
         if (b_valid) cap_b <= '{de: b_de, vs: b_vs, hs: b_hs, rgb: b_data};
      end
   end

   lvdsr_slot_timer #(.SLOTS(SLOTS)) u_timer (
      .clk(clk), .rst(rst), .load_o(load)
   );

   lvdsr_cfg_gate u_cfg (
      .clk(clk), .rst(rst), .a_valid(a_valid), .a_vs(a_vs),
      .mode_cfg(mode_cfg), .wide_cfg(wide_cfg),
      .mode_q(mode_q), .wide_q(wide_q)
   );

   lvdsr_split_demux u_demux (
      .clk(clk), .rst(rst), .in_valid(a_valid), .in_pix(in_a),
      .even_o(split_even), .odd_o(split_odd)
   );

   logic [LANES-1:0] lane_bus [NCH];
   logic [NCH-1:0]   clk_bus;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      pix_t              src;
      logic              en;
      logic [WORD_W-1:0] word;

      always_comb begin
         src = cap_a;
         en  = 1'b1;
         unique case (mode_q)
            M_SINGLE:   en  = (ch == 0);
            M_SEPARATE: src = (ch == 0) ? cap_a : cap_b;
            M_DUAL:     src = cap_a;
            default:    src = (ch == 0) ? split_even : split_odd;
         endcase
      end

      assign word = pack_lanes(src, wide_q);

      lvdsr_chan_ser #(.LANES(LANES), .SLOTS(SLOTS), .CLK_PAT(CLK_PAT)) u_ser (
         .clk(clk), .rst(rst), .load_i(load), .en_i(en), .word_i(word),
         .lane_o(lane_bus[ch]), .clk_o(clk_bus[ch])
      );
   end

   assign ch0_lane_o = lane_bus[0];
   assign ch1_lane_o = lane_bus[1];
   assign ch0_clk_o  = clk_bus[0];
   assign ch1_clk_o  = clk_bus[1];

   // R5: cloned channels are bit-identical
   a_r5_clone: assert property (@(posedge clk) disable iff (rst)
      (load && mode_q == M_DUAL) |=> (ch0_lane_o == ch1_lane_o && ch0_clk_o == ch1_clk_o));
   // R3: channel 1 silent in single mode
   a_r3_single_idle: assert property (@(posedge clk) disable iff (rst)
      (load && mode_q == M_SINGLE) |=> (ch1_lane_o == '0 && !ch1_clk_o));
   // R8: narrow option keeps the top lane low
   a_r8_lane3_low: assert property (@(posedge clk) disable iff (rst)
      (load && !wide_q) |=> (!ch0_lane_o[LANES-1] && !ch1_lane_o[LANES-1]));
endmodule

// File: tb/test_lvds_mode_router.sv
`timescale 1ns/1ps
module test_lvds_mode_router;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic        rst;
   logic [1:0]  mode_cfg;
   logic        wide_cfg;
   logic        a_valid, a_de, a_vs, a_hs;
   logic [23:0] a_data;
   logic        b_valid, b_de, b_vs, b_hs;
   logic [23:0] b_data;
   logic [3:0]  ch0_lane_o, ch1_lane_o;
   logic        ch0_clk_o, ch1_clk_o;

   lvds_mode_router i_lvds_mode_router (
      .clk(clk), .rst(rst), .mode_cfg(mode_cfg), .wide_cfg(wide_cfg),
      .a_valid(a_valid), .a_de(a_de), .a_vs(a_vs), .a_hs(a_hs), .a_data(a_data),
      .b_valid(b_valid), .b_de(b_de), .b_vs(b_vs), .b_hs(b_hs), .b_data(b_data),
      .ch0_lane_o(ch0_lane_o), .ch0_clk_o(ch0_clk_o),
      .ch1_lane_o(ch1_lane_o), .ch1_clk_o(ch1_clk_o)
   );

   // ctrl fields are {de, vs, hs}
   typedef struct packed {
      logic [1:0]  mode;
      logic        wide;
      logic        a_v;  logic [2:0] a_c;  logic [23:0] a_d;
      logic        a2_v; logic [2:0] a2_c; logic [23:0] a2_d;
      logic        b_v;  logic [2:0] b_c;  logic [23:0] b_d;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{2'd0,1'b1, 1'b1,3'b100,24'hA1B2C3, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'h111111}, // R3 single, R8 narrow after reset
      '{2'd1,1'b1, 1'b1,3'b010,24'h0F0F0F, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'h123456}, // R9 frame start -> separate, wide
      '{2'd2,1'b0, 1'b1,3'b100,24'hABCDEF, 1'b0,3'b000,24'h0, 1'b1,3'b101,24'h654321}, // R9 cfg change ignored, R4
      '{2'd2,1'b1, 1'b1,3'b010,24'h00FF00, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'h777777}, // frame start -> dual
      '{2'd2,1'b1, 1'b1,3'b101,24'hC0FFEE, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'hDEAD00}, // R5 B ignored
      '{2'd2,1'b0, 1'b1,3'b011,24'h89ABCD, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0},      // R8 dual narrow
      '{2'd3,1'b1, 1'b1,3'b100,24'h135790, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0},      // R9 no vs rise
      '{2'd3,1'b1, 1'b1,3'b010,24'h2468AC, 1'b1,3'b010,24'hF00F00, 1'b0,3'b000,24'h0}, // switch to split on same pixel
      '{2'd3,1'b1, 1'b1,3'b100,24'h111000, 1'b1,3'b100,24'h000111, 1'b0,3'b000,24'h0}, // R6 line start pair
      '{2'd3,1'b1, 1'b1,3'b101,24'hAAAAAA, 1'b1,3'b100,24'h555555, 1'b0,3'b000,24'h0}, // R6 odd copies even hs
      '{2'd3,1'b1, 1'b1,3'b100,24'h3C3C3C, 1'b1,3'b000,24'hC3C3C3, 1'b0,3'b000,24'h0}, // R6 odd with de low
      '{2'd3,1'b1, 1'b1,3'b000,24'h0A0A0A, 1'b1,3'b100,24'hB0B0B0, 1'b0,3'b000,24'h0}, // R7 held pixel dropped
      '{2'd3,1'b1, 1'b1,3'b100,24'hDDDDDD, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0},      // R7 pairs with line start
      '{2'd3,1'b0, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0},           // R11 repeat word
      '{2'd0,1'b1, 1'b1,3'b010,24'hFEDCBA, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'h999999}, // back to single
      '{2'd0,1'b1, 1'b1,3'b100,24'h5A5A5A, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0},      // R3 R2 R1
      '{2'd0,1'b1, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0}            // flush
   };

   int errors = 0;
   int checks = 0;

   // reference model state
   logic [1:0]  m_mode;
   logic        m_wide, m_vslast, m_ph, m_delast;
   logic [26:0] m_hold, m_ev, m_od, m_capa, m_capb;
   logic [34:0] exp_q [2];
   logic [34:0] act   [2];
   string       exp_tag;

   function automatic string tag_of(logic [1:0] m);
      case (m)
         2'd0:    return "R3";
         2'd1:    return "R4";
         2'd2:    return "R5";
         default: return "R6";
      endcase
   endfunction

   // R8 mapping, pixel as {de, vs, hs, rgb[23:0]}
   function automatic logic [27:0] lanes_of(logic [26:0] p, logic wide);
      return {wide ? {1'b0, p[23:18]} : 7'd0, p[26:24], p[17:14], p[13:7], p[6:0]};
   endfunction

   // R2 clock word in [34:28], lanes 3..0 below
   function automatic logic [34:0] chan_word(int ch);
      logic [26:0] src;
      logic        en;
      en  = 1'b1;
      src = m_capa;
      case (m_mode)
         2'd0: en  = (ch == 0);
         2'd1: src = (ch == 0) ? m_capa : m_capb;
         2'd2: src = m_capa;
         default: src = (ch == 0) ? m_ev : m_od;
      endcase
      return en ? {7'b1100011, lanes_of(src, m_wide)} : 35'd0;
   endfunction

   task automatic model_reset();
      m_mode = 2'd0; m_wide = 1'b0; m_vslast = 1'b0; m_ph = 1'b0; m_delast = 1'b0;
      m_hold = '0; m_ev = '0; m_od = '0; m_capa = '0; m_capb = '0;
      exp_q[0] = '0; exp_q[1] = '0; exp_tag = "R10";
   endtask

   task automatic model_a(logic [26:0] p, logic [1:0] cfg, logic w);
      logic start;
      if (p[25] && !m_vslast) begin m_mode = cfg; m_wide = w; end   // R9
      m_vslast = p[25];
      start    = p[26] && !m_delast;                                 // R7
      m_delast = p[26];
      if (start || !m_ph) begin
         m_hold = p; m_ph = 1'b1;
      end else begin
         m_ev = m_hold; m_od = {m_hold[26:24], p[23:0]}; m_ph = 1'b0;
      end
      m_capa = p;
   endtask

   task automatic check(string tag, int ch, logic [34:0] a, logic [34:0] e);
      checks++;
      if (a !== e) begin
         errors++;
         $display("FAIL %s ch%0d serial word (R1 R2 R8): actual=%h expected=%h", tag, ch, a, e);
      end
   endtask

   task automatic run_period(vec_t v);
      for (int i = 0; i < 7; i++) begin
         act[0][28+6-i] = ch0_clk_o;
         act[1][28+6-i] = ch1_clk_o;
         for (int l = 0; l < 4; l++) begin
            act[0][l*7+6-i] = ch0_lane_o[l];
            act[1][l*7+6-i] = ch1_lane_o[l];
         end
         mode_cfg = v.mode;
         wide_cfg = v.wide;
         a_valid  = 1'b0;
         b_valid  = 1'b0;
         if (i == 1 && v.a_v) begin
            a_valid = 1'b1; {a_de, a_vs, a_hs} = v.a_c; a_data = v.a_d;
            model_a({v.a_c, v.a_d}, v.mode, v.wide);
         end
         if (i == 1 && v.b_v) begin
            b_valid = 1'b1; {b_de, b_vs, b_hs} = v.b_c; b_data = v.b_d;
            m_capb = {v.b_c, v.b_d};
         end
         if (i == 3 && v.a2_v) begin
            a_valid = 1'b1; {a_de, a_vs, a_hs} = v.a2_c; a_data = v.a2_d;
            model_a({v.a2_c, v.a2_d}, v.mode, v.wide);
         end
         @(negedge clk);
      end
      check(exp_tag, 0, act[0], exp_q[0]);
      check(exp_tag, 1, act[1], exp_q[1]);
      exp_q[0] = chan_word(0);
      exp_q[1] = chan_word(1);
      exp_tag  = tag_of(m_mode);
   endtask

   task automatic check_quiet(string what);
      checks++;
      if ({ch0_lane_o, ch0_clk_o, ch1_lane_o, ch1_clk_o} !== 10'd0) begin
         errors++;
         $display("FAIL R10 %s: actual=%b expected=0",
                  what, {ch0_lane_o, ch0_clk_o, ch1_lane_o, ch1_clk_o});
      end
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; mode_cfg = '0; wide_cfg = 1'b0;
      a_valid = 1'b0; a_de = 1'b0; a_vs = 1'b0; a_hs = 1'b0; a_data = '0;
      b_valid = 1'b0; b_de = 1'b0; b_vs = 1'b0; b_hs = 1'b0; b_data = '0;
      model_reset();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      check_quiet("after reset");
      for (int k = 0; k < NV; k++) run_period(VECS[k]);

      // directed: reset mid-stream returns to single/narrow with quiet outputs (R10)
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check_quiet("reset mid-stream");
      rst = 1'b0;
      model_reset();
      run_period('{2'd1,1'b1, 1'b1,3'b100,24'hFFFFFF, 1'b0,3'b000,24'h0, 1'b1,3'b100,24'h424242});
      run_period('{2'd1,1'b1, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0});
      run_period('{2'd1,1'b1, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0, 1'b0,3'b000,24'h0});

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule